// File: doc/BRIEF.md
# Register-Driven SPI Master

This block is a single-lane SPI master that a host CPU controls through a small word-addressed register file. The host writes the shift setup and chip-select choice, then writes one word to the transmit register. That write starts a single frame of 8 or 16 bits. When the frame ends, the received word can be read back and a done flag is set in the cause register. The host polls that flag and clears it by writing zero.

The block does not divide its own clock. A separate prescaler supplies `sck_tick`, a one-cycle enable, and each tick moves SCK by one half period. All four polarity/phase combinations are supported. Bit order is chosen separately for transmit and receive. Eight active-low chip selects are decoded from a 3-bit index and a manual enable bit. A two-bit timing field can push the MISO capture one core clock past the SCK sample edge, for slaves whose read data arrives late at high SCK rates.

The transmit word and all shift settings are latched when a frame starts. Host writes made during the frame therefore do not disturb it.

Top module: `spi_host_ctrl`

## Requirements
- R1: Registers sit at these byte addresses: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, cause 0x10, timing 0x18. Only the defined fields read back; every other bit reads 0. The transmit register reads 0. After reset, timing reads 0x40 and every other register reads 0.
- R2: A write to the transmit register while idle starts exactly one frame. Configuration bit 5 selects the word size: set gives 16 bits, clear gives 8 bits. A frame of N bits produces exactly 2N SCK edges.
- R3: Control bit 0 is the chip-select enable and control bits 4:2 are the index. When enabled, only `spi_cs_n[index]` is low. When disabled, and after reset, all eight lines are high.
- R4: The chip-select lines follow the control register directly. They stay low across back-to-back frames until the host clears the enable bit.
- R5: Configuration bit 11 (CPOL) sets the idle SCK level. Configuration bit 12 (CPHA) sets the edge use. With CPHA=0, MISO is captured on the leading edge and MOSI changes on the trailing edge, with the first bit already on MOSI at frame start. With CPHA=1, MOSI changes on the leading edge and MISO is captured on the trailing edge. SCK changes only on a cycle with `sck_tick` high.
- R6: Configuration bit 13 selects the transmit order: clear sends bit N-1 first, set sends bit 0 first.
- R7: Configuration bit 14 selects the receive order. When clear, the first received bit lands in bit N-1. When set, it lands in bit 0. The receive register holds the whole word in bits N-1:0, with the upper bits at 0 in 8-bit mode.
- R8: Cause bit 0 is cleared when a frame starts, so it reads 0 while a frame is in progress. It is set when the frame ends. A write with bit 0 clear clears it, and a write with bit 0 set has no effect. If a frame ends in the same cycle as a clearing write, the flag is still set.
- R9: A write to the transmit register while a frame is in progress is ignored. The running frame keeps its data and its length.
- R10: Timing bits 7:6 select the MISO capture point. Values 2 and 3 capture one core clock after the sample edge. Values 0 and 1 capture on the sample edge.
- R11: Changes to the configuration or timing registers during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| sck_tick | input | 1 | Half-period enable from the external prescaler |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
Two events can fall in the same core cycle: the end of a frame setting the done flag, and a host write that clears that flag. The bench watches SCK and counts edges. In the cycle after the last edge it drives a zero write to the cause register, which lands on the completion edge. It then requires the flag to read 1. A second overlap is a transmit or configuration write issued while a frame is still shifting. The bench judges that case by the MOSI bit sequence and the edge count that the slave model records, compared with the values the original launch implies.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TXD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RXD    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TIMING = 5'h18;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IDX_LO   = 2;
  localparam int unsigned CFG_WIDE_BIT  = 5;
  localparam int unsigned CFG_CPOL_BIT  = 11;
  localparam int unsigned CFG_CPHA_BIT  = 12;
  localparam int unsigned CFG_TXLSB_BIT = 13;
  localparam int unsigned CFG_RXLSB_BIT = 14;
  localparam int unsigned TIM_SMP_LO    = 6;

  typedef struct packed {
    logic wide;
    logic cpol;
    logic cpha;
    logic tx_lsb;
    logic rx_lsb;
    logic late_smp;
  } frame_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned CS_NUM   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [BUS_W-1:0]            reg_wdata,
  output logic [BUS_W-1:0]            reg_rdata,
  input  logic                        busy,
  input  logic                        launch,
  input  logic                        frame_done,
  input  logic [WORD_MAX-1:0]         rx_word,
  output logic                        txd_wr,
  output logic [WORD_MAX-1:0]         txd_word,
  output frame_cfg_t                  cfg_live,
  output logic                        cs_en,
  output logic [$clog2(CS_NUM)-1:0]   cs_idx
);

  localparam int unsigned IDX_W = $clog2(CS_NUM);

  logic             wr_ctrl, wr_cfg, wr_cause, wr_tim;
  logic             en_q, en_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wide_q, cpol_q, cpha_q, txl_q, rxl_q;
  logic             wide_d, cpol_d, cpha_d, txl_d, rxl_d;
  logic [1:0]       smp_q, smp_d;
  logic [WORD_MAX-1:0] rxd_q;
  logic             done_q, done_d, done_en;

  // write decode and next-state values
  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
    wr_cfg   = reg_we && (reg_addr == OFS_CFG);
    wr_cause = reg_we && (reg_addr == OFS_CAUSE);
    wr_tim   = reg_we && (reg_addr == OFS_TIMING);
    txd_wr   = reg_we && (reg_addr == OFS_TXD);
    txd_word = reg_wdata[WORD_MAX-1:0];

    en_d   = reg_wdata[CTRL_EN_BIT];
    idx_d  = reg_wdata[CTRL_IDX_LO +: IDX_W];
    wide_d = reg_wdata[CFG_WIDE_BIT];
    cpol_d = reg_wdata[CFG_CPOL_BIT];
    cpha_d = reg_wdata[CFG_CPHA_BIT];
    txl_d  = reg_wdata[CFG_TXLSB_BIT];
    rxl_d  = reg_wdata[CFG_RXLSB_BIT];
    smp_d  = reg_wdata[TIM_SMP_LO +: 2];

    // completion has priority over a clearing host write
    done_en = frame_done || launch || (wr_cause && !reg_wdata[0]);
    done_d  = frame_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      idx_q  <= '0;
      wide_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      txl_q  <= 1'b0;
      rxl_q  <= 1'b0;
      smp_q  <= 2'b01;
      rxd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= en_d;
        idx_q <= idx_d;
      end
      if (wr_cfg) begin
        wide_q <= wide_d;
        cpol_q <= cpol_d;
        cpha_q <= cpha_d;
        txl_q  <= txl_d;
        rxl_q  <= rxl_d;
      end
      if (wr_tim)     smp_q  <= smp_d;
      if (frame_done) rxd_q  <= rx_word;
      if (done_en)    done_q <= done_d;
    end
  end

  always_comb begin
    cfg_live.wide     = wide_q;
    cfg_live.cpol     = cpol_q;
    cfg_live.cpha     = cpha_q;
    cfg_live.tx_lsb   = txl_q;
    cfg_live.rx_lsb   = rxl_q;
    cfg_live.late_smp = smp_q[1];
    cs_en  = en_q;
    cs_idx = idx_q;
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_EN_BIT]           = en_q;
        reg_rdata[CTRL_IDX_LO +: IDX_W]  = idx_q;
      end
      OFS_CFG: begin
        reg_rdata[CFG_WIDE_BIT]  = wide_q;
        reg_rdata[CFG_CPOL_BIT]  = cpol_q;
        reg_rdata[CFG_CPHA_BIT]  = cpha_q;
        reg_rdata[CFG_TXLSB_BIT] = txl_q;
        reg_rdata[CFG_RXLSB_BIT] = rxl_q;
      end
      OFS_RXD:    reg_rdata[WORD_MAX-1:0]     = rxd_q;
      OFS_CAUSE:  reg_rdata[0]                = done_q;
      OFS_TIMING: reg_rdata[TIM_SMP_LO +: 2]  = smp_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R8: a completion in the same cycle as a clearing write leaves the flag set
  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> done_q)
    else $error("done flag lost on completion");

  // R8: the flag never reads set while a frame is in progress
  p_busy_cause_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q)
    else $error("done flag set during frame");

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int unsigned WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txd_wr,
  input  logic [WORD_MAX-1:0] txd_word,
  input  frame_cfg_t          cfg_live,
  input  logic                sck_tick,
  input  logic                miso,
  output logic                busy,
  output logic                launch,
  output logic                frame_done,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                sck,
  output logic                mosi
);

  localparam int unsigned IDX_W    = $clog2(WORD_MAX);
  localparam int unsigned EDGE_W   = IDX_W + 1;
  localparam int unsigned WORD_MIN = WORD_MAX / 2;

  eng_state_e          st_q, st_d;
  logic [EDGE_W-1:0]   edge_q, edge_d;
  frame_cfg_t          mode_q, mode_d;
  logic [WORD_MAX-1:0] txw_q, txw_d, rxw_q, rxw_d;
  logic                sck_q, sck_d, mosi_q, mosi_d;
  logic                pend_q, pend_d;
  logic [IDX_W-1:0]    pidx_q, pidx_d;

  logic [EDGE_W-1:0]   nb;
  logic [IDX_W-1:0]    cur, didx;
  logic                lead, smp_edge, last_edge;

  // bit position of the i-th serial bit inside the word
  function automatic logic [IDX_W-1:0] bitpos(input logic lsb, input logic wide,
                                              input logic [IDX_W-1:0] i);
    logic [EDGE_W-1:0] n;
    n = wide ? EDGE_W'(WORD_MAX) : EDGE_W'(WORD_MIN);
    return lsb ? i : IDX_W'(n - EDGE_W'(1) - EDGE_W'(i));
  endfunction

  always_comb begin
    st_d       = st_q;
    edge_d     = edge_q;
    mode_d     = mode_q;
    txw_d      = txw_q;
    rxw_d      = rxw_q;
    sck_d      = sck_q;
    mosi_d     = mosi_q;
    pend_d     = pend_q;
    pidx_d     = pidx_q;
    launch     = 1'b0;
    frame_done = 1'b0;

    nb        = mode_q.wide ? EDGE_W'(WORD_MAX) : EDGE_W'(WORD_MIN);
    cur       = edge_q[EDGE_W-1:1];
    lead      = !edge_q[0];
    smp_edge  = lead ^ mode_q.cpha;
    last_edge = edge_q[0] && (cur == IDX_W'(nb - EDGE_W'(1)));
    didx      = mode_q.cpha ? cur : IDX_W'(cur + 1'b1);

    // delayed capture, one core clock after the sample edge
    if (pend_q) begin
      rxw_d[bitpos(mode_q.rx_lsb, mode_q.wide, pidx_q)] = miso;
      pend_d = 1'b0;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (txd_wr) begin
          launch = 1'b1;
          mode_d = cfg_live;
          txw_d  = txd_word;
          edge_d = '0;
          sck_d  = cfg_live.cpol;
          rxw_d  = '0;
          pend_d = 1'b0;
          mosi_d = cfg_live.cpha ? 1'b0
                 : txd_word[bitpos(cfg_live.tx_lsb, cfg_live.wide, '0)];
          st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (sck_tick) begin
          sck_d  = !sck_q;
          edge_d = edge_q + 1'b1;
          if (smp_edge) begin
            if (mode_q.late_smp) begin
              pend_d = 1'b1;
              pidx_d = cur;
            end else begin
              rxw_d[bitpos(mode_q.rx_lsb, mode_q.wide, cur)] = miso;
            end
          end else if (mode_q.cpha || !last_edge) begin
            mosi_d = txw_q[bitpos(mode_q.tx_lsb, mode_q.wide, didx)];
          end
          if (last_edge) st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        if (!pend_q) begin
          frame_done = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      mode_q <= '0;
      txw_q  <= '0;
      rxw_q  <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      pend_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      mode_q <= mode_d;
      txw_q  <= txw_d;
      rxw_q  <= rxw_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      pend_q <= pend_d;
      pidx_q <= pidx_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign rx_word = rxw_q;
  assign sck     = busy ? sck_q : cfg_live.cpol;
  assign mosi    = mosi_q;

  // R9: a transmit write during a frame leaves the latched word untouched
  p_txd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txd_wr) |=> $stable(txw_q))
    else $error("transmit word changed mid-frame");

  // R11: shift settings hold while the frame runs
  p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> $stable(mode_q))
    else $error("frame settings changed mid-frame");

  // R5: SCK moves only on a tick
  p_sck_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !sck_tick) |=> $stable(sck_q))
    else $error("SCK moved without tick");

endmodule

// File: rtl/spi_host_csdec.sv
module spi_host_csdec #(
  parameter int unsigned CS_NUM = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_en,
  input  logic [$clog2(CS_NUM)-1:0] cs_idx,
  output logic [CS_NUM-1:0]         cs_n
);

  localparam int unsigned IDX_W = $clog2(CS_NUM);

  for (genvar g = 0; g < CS_NUM; g++) begin : g_cs
    assign cs_n[g] = !(cs_en && (cs_idx == IDX_W'(g)));
  end

  // R3: at most one chip select low at any time
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n))
    else $error("more than one chip select active");

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned CS_NUM   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              sck_tick,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_NUM-1:0] spi_cs_n
);

  localparam int unsigned IDX_W = $clog2(CS_NUM);

  logic                busy, launch, frame_done, txd_wr, cs_en;
  logic [WORD_MAX-1:0] rx_word, txd_word;
  logic [IDX_W-1:0]    cs_idx;
  frame_cfg_t          cfg_live;

  spi_host_regs #(
    .BUS_W(BUS_W), .WORD_MAX(WORD_MAX), .CS_NUM(CS_NUM)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .launch(launch), .frame_done(frame_done), .rx_word(rx_word),
    .txd_wr(txd_wr), .txd_word(txd_word), .cfg_live(cfg_live),
    .cs_en(cs_en), .cs_idx(cs_idx)
  );

  spi_host_engine #(
    .WORD_MAX(WORD_MAX)
  ) i_engine (
    .clk(clk), .rst_n(rst_n),
    .txd_wr(txd_wr), .txd_word(txd_word), .cfg_live(cfg_live),
    .sck_tick(sck_tick), .miso(spi_miso),
    .busy(busy), .launch(launch), .frame_done(frame_done), .rx_word(rx_word),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  spi_host_csdec #(
    .CS_NUM(CS_NUM)
  ) i_csdec (
    .clk(clk), .rst_n(rst_n),
    .cs_en(cs_en), .cs_idx(cs_idx), .cs_n(spi_cs_n)
  );

endmodule

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;

  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TXD = 5'h08,
                         A_RXD = 5'h0C, A_CAUSE = 5'h10, A_TIM = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n, reg_we, sck_tick, spi_miso;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sck, spi_mosi;
  logic [7:0]  spi_cs_n;

  always #5 clk = ~clk;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_tick(sck_tick),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_run = 0, n_fail = 0;
  int tick_per = 2;

  // slave model state
  bit          slv_on = 0, slv_cpol, slv_cpha, slv_late;
  int          slv_n, slv_edges, m_cnt, s_ptr, smp_cnt;
  logic [15:0] slv_bits, m_seq;
  logic        prev_sck;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // SCK tick source
  initial begin
    int tcnt = 0;
    sck_tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1 >= tick_per) ? 0 : tcnt + 1;
      sck_tick = (tcnt == 0);
    end
  end

  // SPI slave model
  initial begin
    spi_miso = 1'b0;
    forever begin
      @(negedge clk);
      if (slv_on && (spi_sck !== prev_sck)) begin
        bit lead;
        lead = (prev_sck == slv_cpol);
        prev_sck = spi_sck;
        slv_edges++;
        if (lead ^ slv_cpha) begin
          if (m_cnt < 16) m_seq[m_cnt] = spi_mosi;
          m_cnt++;
          if (slv_late && smp_cnt < 16) spi_miso = slv_bits[smp_cnt];
          smp_cnt++;
        end else if (!slv_late) begin
          if (s_ptr < slv_n) spi_miso = slv_bits[s_ptr];
          s_ptr++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(input bit cpol, cpha, wide, txl, rxl);
    return (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
           (32'(txl) << 13) | (32'(rxl) << 14);
  endfunction

  function automatic logic [15:0] exp_seq(input logic [15:0] tx, input int n, input bit lsb);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s[i] = lsb ? tx[i] : tx[n-1-i];
    return s;
  endfunction

  function automatic logic [15:0] exp_rx(input logic [15:0] sw, input int n, input bit lsb);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (lsb) r[i] = sw[i];
      else     r[n-1-i] = sw[i];
    end
    return r;
  endfunction

  task automatic arm(input bit cpol, cpha, wide, late, input logic [15:0] sw);
    slv_cpol = cpol; slv_cpha = cpha; slv_late = late;
    slv_n = wide ? 16 : 8; slv_bits = sw; m_seq = '0;
    slv_edges = 0; m_cnt = 0; smp_cnt = 0;
    s_ptr = cpha ? 0 : 1;
    spi_miso = (late || cpha) ? 1'b0 : sw[0];
    prev_sck = spi_sck;
    slv_on = 1;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 800; i++) begin
      rd(A_CAUSE, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  // mid: 0 none, 1 transmit rewrite mid-frame, 2 config/timing rewrite mid-frame
  task automatic run_frame(input bit cpol, cpha, wide, txl, rxl, late,
                           input logic [15:0] tx, sw, input int mid);
    int n = wide ? 16 : 8;
    logic [31:0] v;
    bit ok;
    wr(A_CFG, cfgw(cpol, cpha, wide, txl, rxl));
    wr(A_TIM, late ? 32'h80 : 32'h40);
    arm(cpol, cpha, wide, late, sw);
    wr(A_TXD, {16'hA5A5, tx});
    rd(A_CAUSE, v);
    chk(v == 0, "R8 cause low while busy", v, 0);
    if (mid == 1) wr(A_TXD, {16'h0, ~tx});
    if (mid == 2) begin
      wr(A_CFG, cfgw(cpol, !cpha, !wide, !txl, !rxl));
      wr(A_TIM, late ? 32'h40 : 32'h80);
    end
    wait_done(ok);
    chk(ok, "R8 done flag set at frame end", 32'(ok), 1);
    chk(slv_edges == 2*n, mid == 1 ? "R9 edge count" : "R2 edge count", slv_edges, 2*n);
    chk(m_seq == exp_seq(tx, n, txl), mid == 1 ? "R9 mosi bits" :
        mid == 2 ? "R11 mosi bits" : "R6/R5 mosi bits", m_seq, exp_seq(tx, n, txl));
    rd(A_RXD, v);
    chk(v == 32'(exp_rx(sw, n, rxl)), mid == 2 ? "R11 rx word" :
        late ? "R10 rx word" : "R7 rx word", v, 32'(exp_rx(sw, n, rxl)));
    if (mid == 0) chk(spi_sck == cpol, "R5 idle sck level", 32'(spi_sck), 32'(cpol));
    slv_on = 0;
    wr(A_CAUSE, 0);
  endtask

  initial begin
    logic [31:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 8'hFF, "R3 cs high in reset", spi_cs_n, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd(A_TIM, v);   chk(v == 32'h40, "R1 timing reset", v, 32'h40);
    rd(A_CTRL, v);  chk(v == 0, "R1 ctrl reset", v, 0);
    rd(A_CFG, v);   chk(v == 0, "R1 cfg reset", v, 0);
    rd(A_CAUSE, v); chk(v == 0, "R1 cause reset", v, 0);
    rd(A_RXD, v);   chk(v == 0, "R1 rx reset", v, 0);
    chk(spi_sck == 0, "R1 sck idle reset", spi_sck, 0);

    // R1 field readback
    wr(A_CFG, 32'hFFFF_FFFF);  rd(A_CFG, v);  chk(v == 32'h7820, "R1 cfg fields", v, 32'h7820);
    wr(A_TIM, 32'hFFFF_FFFF);  rd(A_TIM, v);  chk(v == 32'hC0, "R1 timing field", v, 32'hC0);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk(v == 32'h1C, "R1 ctrl fields", v, 32'h1C);
    chk(spi_cs_n == 8'hFF, "R3 cs off when disabled", spi_cs_n, 8'hFF);
    rd(A_TXD, v); chk(v == 0, "R1 transmit reads zero", v, 0);
    wr(A_CFG, 0); wr(A_TIM, 32'h40);

    // R3 chip-select decode
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, 32'(i << 2) | 1);
      chk(spi_cs_n == ~(8'd1 << i), "R3 cs decode", spi_cs_n, ~(8'd1 << i));
    end
    wr(A_CTRL, 32'(5 << 2));
    chk(spi_cs_n == 8'hFF, "R3 cs disabled", spi_cs_n, 8'hFF);

    // R4/R5: four modes back to back with cs held
    wr(A_CTRL, 32'(2 << 2) | 1);
    for (int m = 0; m < 4; m++) begin
      run_frame(m[1], m[0], 1'b0, 1'b0, 1'b0, 1'b0, 16'h00C6, 16'h0059, 0);
      chk(spi_cs_n == 8'hFB, "R4 cs held between frames", spi_cs_n, 8'hFB);
    end
    run_frame(1, 1, 1, 1, 0, 0, 16'hBEEF, 16'h1234, 0);
    run_frame(0, 0, 1, 0, 1, 0, 16'h8001, 16'hF00D, 0);

    // R8 cause write semantics
    arm(0, 0, 0, 0, 16'h0);
    wr(A_TXD, 32'h3C);
    begin bit ok; wait_done(ok); end
    slv_on = 0;
    wr(A_CAUSE, 1); rd(A_CAUSE, v); chk(v == 1, "R8 nonzero write keeps flag", v, 1);
    wr(A_CAUSE, 0); rd(A_CAUSE, v); chk(v == 0, "R8 zero write clears", v, 0);

    // R9 / R11 mid-frame writes
    tick_per = 3;
    run_frame(0, 1, 1, 0, 0, 0, 16'h5A3C, 16'h0F0F, 1);
    run_frame(1, 0, 0, 1, 0, 1, 16'h0096, 16'h00E1, 2);
    run_frame(0, 1, 1, 0, 1, 0, 16'hC001, 16'h7E57, 2);

    // R10 late slave with delayed capture
    tick_per = 2;
    run_frame(1, 1, 1, 0, 0, 1, 16'h1357, 16'hACE1, 0);
    run_frame(0, 0, 0, 0, 1, 1, 16'h00A7, 16'h0036, 0);

    // R8 completion and clearing write in the same cycle
    wr(A_CFG, cfgw(0, 0, 0, 0, 0)); wr(A_TIM, 32'h40);
    arm(0, 0, 0, 0, 16'h00AA);
    wr(A_TXD, 32'h55);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (slv_edges == 16) break;
    end
    reg_we = 1; reg_addr = A_CAUSE; reg_wdata = 0;
    @(negedge clk);
    reg_we = 0;
    slv_on = 0;
    rd(A_CAUSE, v); chk(v == 1, "R8 completion beats clear", v, 1);
    wr(A_CAUSE, 0);

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = $urandom;
      tick_per = 2 + int'($urandom % 3);
      run_frame(r[0], r[1], r[2], r[3], r[4], r[5], 16'($urandom), 16'($urandom), 0);
    end
    wr(A_CTRL, 0);
    chk(spi_cs_n == 8'hFF, "R4 cs released on clear", spi_cs_n, 8'hFF);

    summary();
    $finish;
  end

endmodule